// File: doc/BRIEF.md
# Frame-Aligned Triggered Capture Controller

This block sits between a multi-lane channelizer output and a set of per-lane write buffers. A channelizer emits a frame of 512 frequency bins as 128 beats of four samples each, marked with valid, start-of-frame and end-of-frame. Normally nothing passes through. A one-cycle trigger pulse, produced elsewhere from a software register write, arms the controller. The controller then waits for the next start-of-frame beat and forwards exactly one whole frame to the buffers. The last sample of that frame carries a frame-end flag.

Capture never begins part-way through a frame. Cycles with valid low are skipped, so they are neither forwarded nor counted. A one-cycle pulse reports that the capture is complete. A separate one-cycle pulse reports any beat where the incoming end-of-frame marker disagrees with the controller's own beat count.

Top module: `frame_capture_ctrl`

## Requirements
- R1: While reset is held low and in the first cycle after it, `wr_en`, `wr_last`, `done_o` and `err_o` are all 0.
- R2: Without a trigger pulse accepted in the idle state, no beat is ever forwarded (`wr_en` stays 0).
- R3: After a trigger is accepted, forwarding starts with the first later beat that has `in_valid`=1 and `in_sof`=1. A start-of-frame in the same cycle as the trigger does not start a capture. Neither does a start-of-frame with `in_valid`=0.
- R4: One capture forwards exactly `BEATS` (128) beats. Only beats with `in_valid`=1 are forwarded and counted. Cycles with `in_valid`=0 leave `wr_en` at 0.
- R5: Outputs are registered, so a beat presented at clock edge k appears on the `wr_*` outputs in the cycle after edge k. All bits of `wr_en` are equal. Lane i of `wr_data` (bits i*SAMPLE_W and up) equals lane i of `in_data`.
- R6: `wr_last` is 1 only on bit 3 (the highest lane) of the final forwarded beat of a capture, and 0 on every other lane and beat.
- R7: `done_o` is a one-cycle pulse in the same cycle as the final beat's outputs. The block is idle again in the next cycle, where a trigger is accepted.
- R8: Trigger pulses that arrive while the block is armed, capturing, or in its done cycle are ignored, so each accepted trigger yields exactly one frame.
- R9: `err_o` pulses for one cycle, in the cycle after a counted beat, when that beat's `in_eof` differs from "this is beat 128 of the capture". It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | One-cycle capture request |
| in_valid | input | 1 | Input beat valid |
| in_sof | input | 1 | Input beat is the first of a frame |
| in_eof | input | 1 | Input beat is the last of a frame |
| in_data | input | LANES*SAMPLE_W | Four samples of one beat, lane 0 in the low bits |
| wr_en | output | LANES | Per-lane buffer write enable |
| wr_data | output | LANES*SAMPLE_W | Per-lane sample to write |
| wr_last | output | LANES | Per-lane frame-end flag |
| done_o | output | 1 | Capture-complete pulse |
| err_o | output | 1 | End-of-frame marker mismatch pulse |

## Verification
The hardest conditions to reach from the ports are the trigger arriving in exactly the start-of-frame cycle, and a trigger arriving in the single done cycle. Both are narrow windows in time. The bench drives a random frame-structured stream whose position it tracks. To hit the first window, it advances the stream until the next valid beat is a frame start and fires the trigger on that beat. To hit the second, it fires a trigger whenever its own model reports the done cycle. Marker errors are produced by adding a stray end-of-frame mid-frame in one capture and by removing the true end-of-frame marker in another.

// File: rtl/cap_pkg.sv
// Package: shared types of the frame capture controller.
// Assumes: nothing beyond IEEE 1800-2017.
package cap_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2,
        CAP_DONE  = 2'd3
    } cap_state_e;
endpackage

// File: rtl/cap_fsm.sv
// Module: cap_fsm
// Sequences one capture: idle -> armed on trigger, armed -> run on a valid
// start-of-frame beat, run -> done on the last counted beat, done -> idle.
// Assumes: at_last_i comes from the beat counter and refers to the current
// beat; triggers outside idle are dropped by design.
module cap_fsm
    import cap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic in_valid,
    input  logic in_sof,
    input  logic at_last_i,
    output logic take_o,
    output logic done_o
);
    cap_state_e state_q, state_d;

    // Beat acceptance: a valid frame start while armed, any valid beat while running.
    always_comb begin
        take_o = ((state_q == CAP_ARMED) && in_valid && in_sof) ||
                 ((state_q == CAP_RUN) && in_valid);
    end

    // Next-state decision for the capture sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE:  if (trig_i) state_d = CAP_ARMED;
            CAP_ARMED: if (take_o) state_d = CAP_RUN;
            CAP_RUN:   if (take_o && at_last_i) state_d = CAP_DONE;
            CAP_DONE:  state_d = CAP_IDLE;
            default:   state_d = CAP_IDLE;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    assign done_o = (state_q == CAP_DONE);

    assert_arm_needs_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_IDLE && !trig_i) |=> (state_q == CAP_IDLE));
    assert_start_on_sof_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_ARMED && !(in_valid && in_sof)) |=> (state_q == CAP_ARMED));
    assert_run_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_RUN && !(in_valid && at_last_i)) |=> (state_q == CAP_RUN));
    assert_done_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CAP_DONE) |=> (state_q == CAP_IDLE));
endmodule

// File: rtl/cap_beat_counter.sv
// Module: cap_beat_counter
// Counts accepted beats of one capture and flags the final one.
// Assumes: take_i is high only for accepted beats; wraps to 0 after the last.
module cap_beat_counter #(
    parameter int BEATS = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    output logic at_last_o
);
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [CNT_W-1:0] count_q;

    assign at_last_o = (count_q == LAST);

    // Beat count: advance on each accepted beat, restart after the final one.
    always_ff @(posedge clk) begin
        if (!rst_n)                  count_q <= '0;
        else if (take_i && at_last_o) count_q <= '0;
        else if (take_i)             count_q <= count_q + 1'b1;
    end

    assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= LAST);
    assert_count_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !at_last_o) |=> (count_q == $past(count_q) + 1'b1));
    assert_count_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(count_q));
endmodule

// File: rtl/cap_lane_reg.sv
// Module: cap_lane_reg
// Output register of one lane: write enable, sample and frame-end flag.
// Assumes: final_i is only high together with take_i; FLAG_LANE selects the
// one lane that may carry the frame-end flag.
module cap_lane_reg #(
    parameter int SAMPLE_W  = 50,
    parameter bit FLAG_LANE = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_i,
    input  logic                final_i,
    input  logic [SAMPLE_W-1:0] lane_d,
    output logic                wr_en_o,
    output logic [SAMPLE_W-1:0] wr_d_o,
    output logic                wr_last_o
);
    // Lane registers: enable and flag follow the accepted beat; data is sampled each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o   <= 1'b0;
            wr_last_o <= 1'b0;
            wr_d_o    <= '0;
        end else begin
            wr_en_o   <= take_i;
            wr_last_o <= FLAG_LANE && final_i;
            wr_d_o    <= lane_d;
        end
    end

    assert_last_with_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last_o |-> wr_en_o);
endmodule

// File: rtl/frame_capture_ctrl.sv
// Module: frame_capture_ctrl (top)
// Passes exactly one frame-aligned capture of a multi-lane beat stream to
// per-lane buffers after a trigger, tags the final sample, and reports
// completion and end-of-frame marker mismatches.
// Assumes: BEATS >= 2; the stream marks frame starts only on valid beats.
module frame_capture_ctrl #(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 50,
    parameter int BEATS    = 128
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig_i,
    input  logic                      in_valid,
    input  logic                      in_sof,
    input  logic                      in_eof,
    input  logic [LANES*SAMPLE_W-1:0] in_data,
    output logic [LANES-1:0]          wr_en,
    output logic [LANES*SAMPLE_W-1:0] wr_data,
    output logic [LANES-1:0]          wr_last,
    output logic                      done_o,
    output logic                      err_o
);
    logic take;
    logic at_last;
    logic final_beat;

    assign final_beat = take && at_last;

    cap_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig_i),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .at_last_i(at_last),
        .take_o   (take),
        .done_o   (done_o)
    );

    cap_beat_counter #(.BEATS(BEATS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_i   (take),
        .at_last_o(at_last)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cap_lane_reg #(
            .SAMPLE_W (SAMPLE_W),
            .FLAG_LANE(g == LANES - 1)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .take_i   (take),
            .final_i  (final_beat),
            .lane_d   (in_data[g*SAMPLE_W +: SAMPLE_W]),
            .wr_en_o  (wr_en[g]),
            .wr_d_o   (wr_data[g*SAMPLE_W +: SAMPLE_W]),
            .wr_last_o(wr_last[g])
        );
    end

    // Marker check: a counted beat's end-of-frame must match the final-beat position.
    always_ff @(posedge clk) begin
        if (!rst_n) err_o <= 1'b0;
        else        err_o <= take && (in_eof != at_last);
    end

    assert_lanes_agree_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en == '0) || (wr_en == '1));
    assert_single_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_last));
    assert_done_with_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> wr_last[LANES-1]);
    assert_last_gives_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_last[LANES-1] |-> done_o);
endmodule

// File: tb/tb_frame_capture_ctrl.sv
module tb_frame_capture_ctrl;
    localparam int LANES = 4;
    localparam int SW    = 50;
    localparam int BEATS = 128;
    localparam int DW    = LANES * SW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          trig_i, in_valid, in_sof, in_eof;
    logic [DW-1:0] in_data;
    logic [LANES-1:0] wr_en, wr_last;
    logic [DW-1:0] wr_data;
    logic          done_o, err_o;

    int checks = 0, errors = 0;
    int m_st = 0, m_cnt = 0, pos = 0;
    int beats_seen = 0, dones_seen = 0, errs_seen = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    frame_capture_ctrl #(.LANES(LANES), .SAMPLE_W(SW), .BEATS(BEATS)) dut (
        .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .in_valid(in_valid),
        .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data),
        .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
        .done_o(done_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rand_data();
        logic [DW-1:0] d;
        for (int i = 0; i < DW; i++) d[i] = 1'($urandom_range(1));
        return d;
    endfunction

    // One cycle: drive inputs, predict registered outputs, compare after the edge.
    task automatic cyc(input logic t, input logic v, input logic s, input logic e,
                       input logic [DW-1:0] d);
        logic take, lastb, xerr;
        logic [LANES-1:0] xlast;
        int nst;
        trig_i = t; in_valid = v; in_sof = s; in_eof = e; in_data = d;
        take  = (m_st == 1 && v && s) || (m_st == 2 && v);
        lastb = take && (m_cnt == BEATS - 1);
        xerr  = take && (e != lastb);
        xlast = lastb ? {1'b1, {(LANES-1){1'b0}}} : '0;
        nst = m_st;
        case (m_st)
            0: if (t) nst = 1;
            1: if (take) nst = 2;
            2: if (lastb) nst = 3;
            default: nst = 0;
        endcase
        if (take) m_cnt = lastb ? 0 : m_cnt + 1;
        m_st = nst;
        @(posedge clk);
        @(negedge clk);
        chk(wr_en == {LANES{take}}, "R4", "wr_en", 64'(wr_en), 64'({LANES{take}}));
        chk(wr_last == xlast, "R6", "wr_last", 64'(wr_last), 64'(xlast));
        chk(done_o == (nst == 3), "R7", "done_o", 64'(done_o), 64'(nst == 3));
        chk(err_o == xerr, "R9", "err_o", 64'(err_o), 64'(xerr));
        if (take)
            for (int l = 0; l < LANES; l++)
                chk(wr_data[l*SW +: SW] == d[l*SW +: SW], "R5", "wr_data lane",
                    64'(wr_data[l*SW +: SW]), 64'(d[l*SW +: SW]));
        beats_seen += int'(wr_en[0]);
        dones_seen += int'(done_o);
        errs_seen  += int'(err_o);
    endtask

    // One stream cycle: frame-structured beats; bad moves/removes an end marker.
    task automatic str(input logic t, input int vpct, input int bad);
        logic v, s, e;
        v = ($urandom_range(99) < vpct);
        s = v && (pos == 0);
        e = v && ((pos == BEATS - 1) ^ (pos == bad));
        cyc(t, v, s, e, rand_data());
        if (v) pos = (pos + 1) % BEATS;
    endtask

    // A full capture: trigger from idle, run until idle again.
    task automatic capture(input int vpct, input int bad, input bit noise);
        int b0, d0, e0;
        b0 = beats_seen; d0 = dones_seen; e0 = errs_seen;
        str(1'b1, vpct, bad);
        while (m_st != 0) begin
            logic t;
            t = noise && ((m_st == 3) || ($urandom_range(3) == 0));
            str(t, vpct, bad);
        end
        chk(beats_seen - b0 == BEATS, "R4", "beats per capture", 64'(beats_seen - b0), 64'(BEATS));
        chk(dones_seen - d0 == 1, "R7", "done pulses", 64'(dones_seen - d0), 64'd1);
        chk(errs_seen - e0 == ((bad >= 0) ? 1 : 0), "R9", "err pulses",
            64'(errs_seen - e0), 64'((bad >= 0) ? 1 : 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R4 watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int b0;
        void'($urandom(32'd1234));
        rst_n = 1'b0; trig_i = 1'b1; in_valid = 1'b1; in_sof = 1'b1; in_eof = 1'b1;
        in_data = '1;
        // R1: reset holds outputs low even with active-looking inputs
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(wr_en == '0 && wr_last == '0, "R1", "lane outputs in reset",
            64'({wr_en, wr_last}), 64'd0);
        chk(!done_o && !err_o, "R1", "status in reset", 64'({done_o, err_o}), 64'd0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b0, 1'b0, '0);
        chk(wr_en == '0 && !done_o && !err_o, "R1", "first cycle after reset",
            64'({wr_en, done_o, err_o}), 64'd0);

        // R2: long stream with no trigger forwards nothing
        b0 = beats_seen;
        repeat (400) str(1'b0, 80, -1);
        chk(beats_seen == b0, "R2", "beats without trigger", 64'(beats_seen - b0), 64'd0);

        // R3: trigger in the very start-of-frame cycle does not start on that frame
        while (pos != 0) str(1'b0, 100, -1);
        b0 = beats_seen;
        str(1'b1, 100, -1);
        chk(m_st == 1 && wr_en == '0, "R3", "sof with trigger not taken",
            64'(wr_en), 64'd0);
        // R3: start-of-frame without valid while armed is not a start
        cyc(1'b0, 1'b0, 1'b1, 1'b0, rand_data());
        chk(wr_en == '0, "R3", "sof without valid", 64'(wr_en), 64'd0);
        while (m_st != 0) str(1'b0, 70, -1);
        chk(beats_seen - b0 == BEATS, "R3", "aligned capture length",
            64'(beats_seen - b0), 64'(BEATS));

        // R4/R5/R6/R7: random captures with varied valid density
        for (int k = 0; k < 5; k++) capture(30 + 15 * k, -1, 1'b0);

        // R8: triggers during armed, capture and done are ignored
        capture(60, -1, 1'b1);
        b0 = beats_seen;
        repeat (400) str(1'b0, 90, -1);
        chk(beats_seen == b0, "R8", "no second capture", 64'(beats_seen - b0), 64'd0);

        // R7: trigger right after done (idle) is accepted
        capture(100, -1, 1'b0);
        capture(100, -1, 1'b0);

        // R9: stray end marker mid-frame, then missing end marker
        capture(75, 50, 1'b0);
        capture(75, BEATS - 1, 1'b0);
        capture(75, -1, 1'b0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule